// File: doc/BRIEF.md
# Serial Huffman Test-Symbol Decoder

This block turns a serial, prefix-free Huffman bitstream back into 3-bit test-vector symbols. A feeder presents one code bit per clock, qualified by a valid strobe. The decoder emits a 3-bit symbol with a one-cycle valid pulse on the cycle whose bit completes a codeword. The codebook is fixed in hardware and has eight entries. The most frequent pattern, 000, has the 1-bit codeword `0`. Rarer patterns get longer codewords.

The code is unary-like. The number of leading ones picks the symbol, and a zero closes the codeword. A run of seven ones is a complete codeword on its own and needs no closing zero. The only state is a counter of consecutive ones, so the decoder can take a new bit on every clock with no stall. A flush input drops any partial codeword. If a partial codeword was pending when the flush arrived, the block raises an error flag in that cycle.

Top module: `hufsym_decoder`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) discards any partial codeword. The first bit accepted after reset therefore starts a new codeword: a `0` decodes as 000, and a flush finds nothing pending.
- R2: A `0` bit preceded by k ones closes a codeword, with k from 0 to 6. The symbol is, by k: 0→000, 1→010, 2→001, 3→011, 4→110, 5→101, 6→111. The symbol is given MSB-first on `sym_out[2:0]`.
- R3: The seventh consecutive `1` ends the codeword at once with symbol 100. The next accepted bit starts a new codeword.
- R4: `sym_valid` is high only in a cycle where `bit_valid` is high, `flush` is low and the current bit completes a codeword. It is driven in the same cycle as that bit.
- R5: In a cycle with `bit_valid` low (and no flush), `bit_in` is ignored. The partial codeword is unchanged and no symbol is produced.
- R6: `flush` clears the partial codeword. `err` is high in the flush cycle exactly when at least one `1` was pending, and `err` is never high outside a flush cycle.
- R7: In a flush cycle, the bit on `bit_in` is dropped even if `bit_valid` is high, and `sym_valid` stays low.
- R8: Codewords sent back to back, one bit per clock with no idle cycles, all decode correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial code bit |
| flush | input | 1 | Discard any partial codeword |
| sym_valid | output | 1 | One-cycle pulse: a codeword ended this cycle |
| sym_out | output | 3 | Decoded test-vector symbol |
| err | output | 1 | Flush arrived while a partial codeword was pending |

## Verification
The only internal state is the run-of-ones count. If that count is wrong, the error shows up at the next codeword-ending bit as a wrong `sym_out`. It can also show up as a missing or extra `sym_valid` on the seventh `1`, or as a wrong `err` on the next flush. So a corrupted count becomes visible no more than seven accepted bits later. The bench keeps a count model of its own and compares all three outputs on every cycle. Its random bits are biased toward ones so that long runs and the seven-ones end are reached often, and flushes land at every count.

// File: rtl/hufsym_pkg.sv
package hufsym_pkg;

    // longest run of ones; a run this long is a complete codeword
    localparam int CODE_MAX = 7;
    localparam int NSYM     = CODE_MAX + 1;
    localparam int SYM_W    = $clog2(NSYM);
    localparam int RUN_W    = $clog2(CODE_MAX);
    localparam int LEN_W    = $clog2(CODE_MAX + 1);

    typedef struct packed {
        logic [RUN_W-1:0] run;
    } run_state_t;

    // symbol assigned to a codeword with n leading ones
    function automatic logic [SYM_W-1:0] sym_of_run(input int n);
        case (n)
            0:       return 3'b000;
            1:       return 3'b010;
            2:       return 3'b001;
            3:       return 3'b011;
            4:       return 3'b110;
            5:       return 3'b101;
            6:       return 3'b111;
            default: return 3'b100;
        endcase
    endfunction

endpackage

// File: rtl/hufsym_run_ctr.sv
module hufsym_run_ctr
    import hufsym_pkg::*;
#(
    parameter int MAX_RUN = CODE_MAX
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_valid,
    input  logic             bit_in,
    input  logic             flush,
    output logic             done,
    output logic [LEN_W-1:0] len,
    output logic             pend_err,
    output logic [RUN_W-1:0] run_q
);

    run_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        done     = 1'b0;
        len      = '0;
        pend_err = 1'b0;
        if (flush) begin
            pend_err   = (st_q.run != '0);
            st_d.run   = '0;
        end else if (bit_valid) begin
            if (!bit_in) begin
                done     = 1'b1;
                len      = LEN_W'(st_q.run);
                st_d.run = '0;
            end else if (st_q.run == RUN_W'(MAX_RUN - 1)) begin
                done     = 1'b1;
                len      = LEN_W'(MAX_RUN);
                st_d.run = '0;
            end else begin
                st_d.run = st_q.run + RUN_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign run_q = st_q.run;

endmodule

// File: rtl/hufsym_map.sv
module hufsym_map
    import hufsym_pkg::*;
(
    input  logic [LEN_W-1:0] len,
    output logic [SYM_W-1:0] sym
);

    logic [SYM_W-1:0] table_w [NSYM];

    for (genvar g = 0; g < NSYM; g++) begin : g_entry
        assign table_w[g] = sym_of_run(g);
    end

    assign sym = table_w[len];

endmodule

// File: rtl/hufsym_decoder.sv
module hufsym_decoder
    import hufsym_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_valid,
    input  logic             bit_in,
    input  logic             flush,
    output logic             sym_valid,
    output logic [SYM_W-1:0] sym_out,
    output logic             err
);

    logic             done_w;
    logic [LEN_W-1:0] len_w;
    logic [RUN_W-1:0] run_q;

    hufsym_run_ctr #(.MAX_RUN(CODE_MAX)) u_run (
        .clk      (clk),
        .rst      (rst),
        .bit_valid(bit_valid),
        .bit_in   (bit_in),
        .flush    (flush),
        .done     (done_w),
        .len      (len_w),
        .pend_err (err),
        .run_q    (run_q)
    );

    hufsym_map u_map (
        .len(len_w),
        .sym(sym_out)
    );

    assign sym_valid = done_w;

endmodule

// File: rtl/hufsym_decoder_chk.sv
module hufsym_decoder_chk
    import hufsym_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bit_valid,
    input logic             bit_in,
    input logic             flush,
    input logic             sym_valid,
    input logic [SYM_W-1:0] sym_out,
    input logic             err,
    input logic [RUN_W-1:0] run_q
);

    // R4
    sym_needs_bit_chk: assert property (@(posedge clk) disable iff (rst)
        sym_valid |-> (bit_valid && !flush));

    // R2
    zero_closes_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && !bit_in && !flush) |-> sym_valid);

    // R3
    seventh_one_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && bit_in && !flush && run_q == RUN_W'(CODE_MAX - 1))
            |-> (sym_valid && sym_out == 3'b100));

    // R3
    run_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run_q <= RUN_W'(CODE_MAX - 1));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!bit_valid && !flush) |=> $stable(run_q));

    // R6
    flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (run_q == '0));

    // R6
    err_only_flush_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> (flush && run_q != '0));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (run_q == '0));

endmodule

bind hufsym_decoder hufsym_decoder_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bit_valid(bit_valid),
    .bit_in   (bit_in),
    .flush    (flush),
    .sym_valid(sym_valid),
    .sym_out  (sym_out),
    .err      (err),
    .run_q    (run_q)
);

// File: tb/hufsym_decoder_bench.sv
module hufsym_decoder_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       bit_valid, bit_in, flush;
    logic       sym_valid;
    logic [2:0] sym_out;
    logic       err;

    int n_chk  = 0;
    int n_fail = 0;
    int m_run  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    hufsym_decoder u_hufsym_decoder (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
        .flush(flush), .sym_valid(sym_valid), .sym_out(sym_out), .err(err)
    );

    function automatic logic [2:0] exp_sym(input int k);
        case (k)
            0: return 3'b000; 1: return 3'b010; 2: return 3'b001;
            3: return 3'b011; 4: return 3'b110; 5: return 3'b101;
            6: return 3'b111; default: return 3'b100;
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // drive one cycle, compare against the count model, then advance it
    task automatic step(input logic v, input logic b, input logic f, input string tag);
        logic e_valid, e_err;
        logic [2:0] e_sym;
        int nxt;
        @(negedge clk);
        bit_valid = v; bit_in = b; flush = f;
        #5;
        e_valid = 1'b0; e_err = 1'b0; e_sym = 3'b000; nxt = m_run;
        if (f) begin
            e_err = (m_run != 0); nxt = 0;
        end else if (v) begin
            if (!b) begin
                e_valid = 1'b1; e_sym = exp_sym(m_run); nxt = 0;
            end else if (m_run == 6) begin
                e_valid = 1'b1; e_sym = exp_sym(7); nxt = 0;
            end else begin
                nxt = m_run + 1;
            end
        end
        check(tag, "sym_valid", int'(sym_valid), int'(e_valid));
        check(tag, "err", int'(err), int'(e_err));
        if (e_valid) check(tag, "sym_out", int'(sym_out), int'(e_sym));
        m_run = nxt;
    endtask

    task automatic send_code(input int k, input string tag);
        for (int i = 0; i < k && i < 7; i++) step(1'b1, 1'b1, 1'b0, tag);
        if (k < 7) step(1'b1, 1'b0, 1'b0, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bit_valid = 1'b0; bit_in = 1'b0; flush = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_run = 0;
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        string tg;
        logic v, b, f;
        void'($urandom(32'd20240611));
        rst = 1'b1; bit_valid = 1'b0; bit_in = 1'b0; flush = 1'b0;
        do_reset();

        // R1: reset state, idle outputs quiet and nothing pending
        step(1'b0, 1'b0, 1'b0, "R1");
        step(1'b0, 1'b0, 1'b1, "R1");

        // R2: every zero-terminated codeword
        for (int k = 0; k < 7; k++) send_code(k, "R2");

        // R3: seven ones, then the following bit starts afresh
        send_code(7, "R3");
        step(1'b1, 1'b0, 1'b0, "R3");
        for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 1'b0, "R3");
        step(1'b1, 1'b0, 1'b0, "R3");

        // R5: idle cycles with toggling data inside a codeword
        step(1'b1, 1'b1, 1'b0, "R5");
        step(1'b0, 1'b0, 1'b0, "R5");
        step(1'b0, 1'b1, 1'b0, "R5");
        step(1'b1, 1'b1, 1'b0, "R5");
        step(1'b0, 1'b0, 1'b0, "R5");
        step(1'b1, 1'b0, 1'b0, "R5");

        // R6: flush with and without a pending partial codeword
        step(1'b1, 1'b1, 1'b0, "R6");
        step(1'b1, 1'b1, 1'b0, "R6");
        step(1'b0, 1'b0, 1'b1, "R6");
        step(1'b1, 1'b0, 1'b0, "R6");
        step(1'b0, 1'b0, 1'b1, "R6");

        // R7: flush with a valid zero bit in the same cycle
        step(1'b1, 1'b1, 1'b0, "R7");
        step(1'b1, 1'b0, 1'b1, "R7");
        step(1'b1, 1'b0, 1'b0, "R7");

        // R1: reset in the middle of a codeword
        step(1'b1, 1'b1, 1'b0, "R1");
        step(1'b1, 1'b1, 1'b0, "R1");
        do_reset();
        step(1'b1, 1'b0, 1'b0, "R1");
        step(1'b1, 1'b1, 1'b0, "R1");
        do_reset();
        step(1'b0, 1'b0, 1'b1, "R1");

        // R8: back-to-back codewords, no gaps
        for (int k = 7; k >= 0; k--) send_code(k, "R8");

        // random mix, biased toward ones
        for (int i = 0; i < 4000; i++) begin
            v = (($urandom % 5) != 0);
            b = (($urandom % 4) != 0);
            f = (($urandom % 23) == 0);
            if (f)                    tg = "R6";
            else if (!v)              tg = "R5";
            else if (b && m_run == 6) tg = "R3";
            else if (!b)              tg = "R2";
            else                      tg = "R8";
            step(v, b, f, tg);
        end

        // R4: a quiet cycle after traffic produces no symbol
        step(1'b0, 1'b1, 1'b0, "R4");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule